// File: doc/BRIEF.md
# Doorbell-Gated Command Sequence Executor

This block is the fetch and dispatch front end of a command execution unit. It takes command bytes from a queue over a valid/ready handshake. Bus-acquire and bus-release markers bracket each command sequence, and idle-wait bytes are swallowed. Every other byte is passed downstream one cycle after it is accepted.

A signed 8-bit credit counter gates the start of each sequence. Software adds signed amounts to the counter through a write strobe. Hardware takes one unit each time it accepts a bus-acquire byte. If no credit is left, the executor holds the bus-acquire byte at the head of the queue until software raises the count above zero. One write can release several queued sequences at once.

An execution-disable input lets the executor finish the bytes that are already streaming in. Once the queue runs dry it stops fetching. Fetching resumes only after the bit is cleared.

Top module: `doorbell_sequencer`

## Requirements
- R1: After reset the credit count is 0, no byte is dispatched, the fault flag is 0 and, with no byte offered, idle is 1.
- R2: A cycle with `bell_wr` high adds the two's-complement value on `bell_val` to the count, modulo 256. The new count is visible on `bell_count` after the next rising edge.
- R3: A bus-acquire byte (0xA1) is accepted only when the count is positive. It lowers the count by 1 and is dispatched unchanged one cycle after acceptance.
- R4: While the count is zero or negative, an offered bus-acquire byte is held: `cmd_ready` stays 0, nothing is dispatched and the count does not change. The byte is accepted once a write makes the count positive. A write of N lets N queued sequences start.
- R5: If a software add and a bus-acquire acceptance fall in the same cycle, the count becomes count + value - 1.
- R6: A wait byte (0xA0) is consumed with no dispatch. Every other byte, including bus-release (0xA2), is dispatched unchanged, in order, one cycle after acceptance.
- R7: With `exec_off` at 1, bytes offered back to back continue to be accepted. After a cycle with no byte offered, no further byte is accepted until `exec_off` returns to 0. Fetching then resumes.
- R8: `idle` is 1 only when no sequence is open (the last marker seen was a bus-release, or none was seen), no byte is offered and no dispatch is pending. It is 0 between a bus-acquire and its bus-release.
- R9: The sequence state uses two legal encodings. If any other encoding appears, `sm_bad` is raised and latched, and the state returns to "outside a sequence". In legal operation `sm_bad` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_byte | input | 8 | Command byte at the head of the queue |
| cmd_valid | input | 1 | Queue has a byte to offer |
| cmd_ready | output | 1 | Executor accepts the offered byte this cycle |
| bell_wr | input | 1 | Software doorbell write strobe |
| bell_val | input | 8 | Signed amount added to the credit count |
| exec_off | input | 1 | Execution disable: stop fetching once the queue drains |
| disp_byte | output | 8 | Dispatched command byte |
| disp_valid | output | 1 | `disp_byte` is valid this cycle |
| idle | output | 1 | No open sequence, no byte offered, nothing pending |
| bell_count | output | 8 | Current two's-complement credit count |
| sm_bad | output | 1 | Sticky flag: sequence state held an unused encoding |

## Verification
The assertions assume a few things about the inputs:
- `cmd_byte` is held stable while `cmd_valid` is high and no handshake has completed.
- `cmd_valid` is low in the cycle that is meant to signal an empty queue.
- The doorbell value is meaningful only when `bell_wr` is high.

The stimulus drives every input on the falling clock edge. It keeps a stalled bus-acquire byte on the port until it is accepted. It drops `cmd_valid` for whole cycles to mark a drained queue. Doorbell writes never push the count past the signed 8-bit range except where wrap is intended.

// File: rtl/dbx_pkg.sv
package dbx_pkg;

    // Sequence state: two legal encodings, the others are fault codes
    typedef enum logic [1:0] {
        SQ_OUT = 2'b01,
        SQ_IN  = 2'b10
    } seq_state_t;

    localparam logic [7:0] OPC_ACQUIRE = 8'hA1;
    localparam logic [7:0] OPC_RELEASE = 8'hA2;
    localparam logic [7:0] OPC_WAIT    = 8'hA0;

endpackage

// File: rtl/dbx_opdec.sv
module dbx_opdec #(
    parameter int          BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] ACQ_CODE = 8'hA1,
    parameter logic [BYTE_W-1:0] REL_CODE = 8'hA2,
    parameter logic [BYTE_W-1:0] WAIT_CODE = 8'hA0
) (
    input  logic [BYTE_W-1:0] op_byte,
    output logic              op_acq,
    output logic              op_rel,
    output logic              op_wait
);
    always_comb begin
        op_acq  = (op_byte == ACQ_CODE);
        op_rel  = (op_byte == REL_CODE);
        op_wait = (op_byte == WAIT_CODE);
    end
endmodule

// File: rtl/dbx_credit.sv
module dbx_credit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_val,
    input  logic             take,
    output logic [CNT_W-1:0] count,
    output logic             has_credit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cred_t;

    cred_t cr_d, cr_q;

    always_comb begin
        cr_d = cr_q;
        if (add_en)
            cr_d.cnt = cr_d.cnt + add_val;
        if (take)
            cr_d.cnt = cr_d.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cr_q <= '0;
        else
            cr_q <= cr_d;
    end

    assign count      = cr_q.cnt;
    assign has_credit = !cr_q.cnt[CNT_W-1] && (cr_q.cnt != '0);

    a_r2_add_only: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !take) |=> count == $past(count) + $past(add_val));
    a_r3_take_only: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !add_en) |=> count == $past(count) - CNT_W'(1));
    a_r5_add_and_take: assert property (@(posedge clk) disable iff (!rst_n)
        (take && add_en) |=> count == $past(count) + $past(add_val) - CNT_W'(1));
    a_r4_idle_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !add_en) |=> $stable(count));
endmodule

// File: rtl/dbx_seq_ctl.sv
module dbx_seq_ctl
    import dbx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              is_acq,
    input  logic              is_rel,
    input  logic              is_wait,
    input  logic              has_credit,
    input  logic              exec_off,
    output logic              in_ready,
    output logic              take,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_valid,
    output logic              idle,
    output logic              sm_bad
);
    typedef struct packed {
        seq_state_t        st;
        logic              halt;
        logic              bad;
        logic              ov;
        logic [BYTE_W-1:0] ob;
    } ctl_t;

    ctl_t c_d, c_q;
    logic legal_st;
    logic accept;

    always_comb begin
        legal_st = (c_q.st == SQ_OUT) || (c_q.st == SQ_IN);
        in_ready = !c_q.halt && legal_st && !(is_acq && !has_credit);
        accept   = in_valid && in_ready;
        take     = accept && is_acq;

        c_d      = c_q;
        c_d.ov   = 1'b0;
        c_d.halt = exec_off && (c_q.halt || !in_valid);

        case (c_q.st)
            SQ_OUT, SQ_IN: begin
                if (accept) begin
                    if (is_acq) c_d.st = SQ_IN;
                    if (is_rel) c_d.st = SQ_OUT;
                    if (!is_wait) begin
                        c_d.ov = 1'b1;
                        c_d.ob = in_byte;
                    end
                end
            end
            default: begin
                c_d.bad = 1'b1;
                c_d.st  = SQ_OUT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st   <= SQ_OUT;
            c_q.halt <= 1'b0;
            c_q.bad  <= 1'b0;
            c_q.ov   <= 1'b0;
            c_q.ob   <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign out_byte  = c_q.ob;
    assign out_valid = c_q.ov;
    assign idle      = (c_q.st == SQ_OUT) && !in_valid && !c_q.ov;
    assign sm_bad    = c_q.bad;

    a_r7_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.halt |-> !in_ready);
    a_r6_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_wait) |=> !out_valid);
    a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_wait) |=> (out_valid && out_byte == $past(in_byte)));
    a_r8_open_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == SQ_IN) |-> !idle);
    a_r9_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        !sm_bad |-> legal_st);
endmodule

// File: rtl/doorbell_sequencer.sv
module doorbell_sequencer
    import dbx_pkg::*;
#(
    parameter int                BYTE_W    = 8,
    parameter int                CNT_W     = 8,
    parameter logic [BYTE_W-1:0] ACQ_CODE  = OPC_ACQUIRE,
    parameter logic [BYTE_W-1:0] REL_CODE  = OPC_RELEASE,
    parameter logic [BYTE_W-1:0] WAIT_CODE = OPC_WAIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              bell_wr,
    input  logic [CNT_W-1:0]  bell_val,
    input  logic              exec_off,
    output logic [BYTE_W-1:0] disp_byte,
    output logic              disp_valid,
    output logic              idle,
    output logic [CNT_W-1:0]  bell_count,
    output logic              sm_bad
);
    logic op_acq, op_rel, op_wait;
    logic has_credit, take;

    dbx_opdec #(
        .BYTE_W   (BYTE_W),
        .ACQ_CODE (ACQ_CODE),
        .REL_CODE (REL_CODE),
        .WAIT_CODE(WAIT_CODE)
    ) u_dec (
        .op_byte(cmd_byte),
        .op_acq (op_acq),
        .op_rel (op_rel),
        .op_wait(op_wait)
    );

    dbx_credit #(.CNT_W(CNT_W)) u_credit (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_en    (bell_wr),
        .add_val   (bell_val),
        .take      (take),
        .count     (bell_count),
        .has_credit(has_credit)
    );

    dbx_seq_ctl #(.BYTE_W(BYTE_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (cmd_valid),
        .in_byte   (cmd_byte),
        .is_acq    (op_acq),
        .is_rel    (op_rel),
        .is_wait   (op_wait),
        .has_credit(has_credit),
        .exec_off  (exec_off),
        .in_ready  (cmd_ready),
        .take      (take),
        .out_byte  (disp_byte),
        .out_valid (disp_valid),
        .idle      (idle),
        .sm_bad    (sm_bad)
    );

    a_r4_acq_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_byte == ACQ_CODE) |-> $signed(bell_count) > 0);
    a_r3_acq_dispatched: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_byte == ACQ_CODE) |=> (disp_valid && disp_byte == ACQ_CODE));
endmodule

// File: tb/doorbell_sequencer_test.sv
module doorbell_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic       bell_wr = 1'b0;
    logic [7:0] bell_val = 8'h00;
    logic       exec_off = 1'b0;
    logic [7:0] disp_byte;
    logic       disp_valid;
    logic       idle;
    logic [7:0] bell_count;
    logic       sm_bad;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    doorbell_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .bell_wr(bell_wr), .bell_val(bell_val),
        .exec_off(exec_off), .disp_byte(disp_byte), .disp_valid(disp_valid),
        .idle(idle), .bell_count(bell_count), .sm_bad(sm_bad)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every dispatch
    always @(negedge clk) begin
        if (rst_n && disp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected dispatch", int'(disp_byte), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(disp_byte == e, "R6 dispatch order/value", int'(disp_byte), int'(e));
            end
        end
    end

    // driver: called at a falling edge, returns at a falling edge
    task automatic put(input logic [7:0] b, input bit hold);
        int n = 0;
        cmd_valid = 1'b1;
        cmd_byte  = b;
        #1;
        while (!cmd_ready && n < 50) begin
            @(negedge clk);
            #1;
            n++;
        end
        if (b != 8'hA0) exp_q.push_back(b);
        @(negedge clk);
        if (!hold) cmd_valid = 1'b0;
    endtask

    task automatic ring(input logic [7:0] v);
        bell_wr  = 1'b1;
        bell_val = v;
        @(negedge clk);
        bell_wr  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(bell_count == 8'h00, "R1 count", int'(bell_count), 0);
        chk(!disp_valid, "R1 dispatch", int'(disp_valid), 0);
        chk(idle, "R1 idle", int'(idle), 1);
        chk(!sm_bad, "R1 sm_bad", int'(sm_bad), 0);

        // R2 signed add
        ring(8'd2);
        chk(bell_count == 8'd2, "R2 add +2", int'(bell_count), 2);

        // R3 one sequence with wait and plain bytes
        put(8'hA1, 0);
        chk(bell_count == 8'd1, "R3 acquire decrements", int'(bell_count), 1);
        chk(!idle, "R8 not idle inside sequence", int'(idle), 0);
        put(8'h55, 0);
        put(8'hA0, 0);
        put(8'h66, 0);
        put(8'hA2, 0);
        @(negedge clk);
        chk(idle, "R8 idle after release", int'(idle), 1);

        // R4 stall at zero and negative count
        ring(8'hFF);
        chk(bell_count == 8'h00, "R2 add -1", int'(bell_count), 0);
        cmd_valid = 1'b1;
        cmd_byte  = 8'hA1;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(!cmd_ready, "R4 stalled at zero", int'(cmd_ready), 0);
            @(negedge clk);
            chk(!disp_valid, "R4 no dispatch while stalled", int'(disp_valid), 0);
        end
        ring(8'hFD);
        chk(bell_count == 8'hFD, "R2 add -3 negative", int'(bell_count), 8'hFD);
        #1;
        chk(!cmd_ready, "R4 stalled at negative", int'(cmd_ready), 0);
        @(negedge clk);
        chk(bell_count == 8'hFD, "R4 count unchanged while stalled", int'(bell_count), 8'hFD);
        ring(8'd5);
        chk(bell_count == 8'd2, "R4 count raised to 2", int'(bell_count), 2);
        // two sequences released by one write
        put(8'hA1, 0);
        put(8'h31, 0);
        put(8'hA2, 0);
        put(8'hA1, 0);
        put(8'hA2, 0);
        chk(bell_count == 8'd0, "R4 two sequences used two credits", int'(bell_count), 0);

        // R5 simultaneous add and acquire
        ring(8'd3);
        cmd_valid = 1'b1;
        cmd_byte  = 8'hA1;
        bell_wr   = 1'b1;
        bell_val  = 8'd4;
        #1;
        chk(cmd_ready, "R5 acquire accepted", int'(cmd_ready), 1);
        exp_q.push_back(8'hA1);
        @(negedge clk);
        cmd_valid = 1'b0;
        bell_wr   = 1'b0;
        chk(bell_count == 8'd6, "R5 count+value-1", int'(bell_count), 6);
        put(8'hA2, 0);

        // R7 execution disable
        exec_off = 1'b1;
        put(8'h11, 1);
        put(8'h12, 0);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = 8'h22;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(!cmd_ready, "R7 blocked after drain", int'(cmd_ready), 0);
            @(negedge clk);
            chk(!disp_valid, "R7 no dispatch while disabled", int'(disp_valid), 0);
        end
        exec_off = 1'b0;
        put(8'h22, 0);
        @(negedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        chk(!sm_bad, "R9 sm_bad stays low", int'(sm_bad), 0);
        chk(idle, "R8 idle at end", int'(idle), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule